// File: doc/BRIEF.md
# Fractional-Step Time-of-Day Counter

This block keeps a precision time-of-day value for a network timestamping path. The value has a 48-bit seconds part and a 30-bit nanoseconds part. A hidden 16-bit fraction accumulator lets the counter follow clock rates that do not divide one second evenly. On every clock the nanoseconds advance by an 8-bit whole step. A 16-bit fraction is added into the accumulator at the same time, and a carry out of it adds one more nanosecond on that clock. When the nanoseconds reach one billion they wrap and the seconds count up.

Software reaches the block through a plain register port with a write strobe, an address and a combinational read path. Several values are staged so that software sees them change as a whole. The fractional step is held until the whole-nanosecond step register is written. The upper seconds word is held until the lower seconds word is written. A signed one-shot adjust register moves the time by a number of nanoseconds without touching the step.

A capture strobe takes a snapshot of the current time as a compact timestamp: all 30 nanosecond bits and the six low bits of seconds. The snapshot leaves the block on a valid/ready output. Once `cap_valid` is high, the words stay stable until a cycle in which `cap_ready` is high. A strobe that arrives while a word is held and not being taken is dropped. A strobe in the same cycle as a hand-off loads the new word.

Top module: `ptp_tod_counter`

## Requirements
- R1: While reset is asserted, and after it is released, the nanoseconds, seconds, active step, active fraction, fraction accumulator and capture valid are all zero.
- R2: On each clock without a time write, the nanoseconds grow by the active whole step plus one more when the 16-bit accumulator plus the active fraction carries out of bit 15. With step 8 and fraction 0x8000, the count grows by exactly 17 every two clocks.
- R3: When the sum reaches 1,000,000,000 or more, 1,000,000,000 is taken off and the 48-bit seconds go up by one, with the carry crossing from bit 31 into bit 32. The nanoseconds always stay below 1,000,000,000.
- R4: Address 4 (sub-step) stages the fraction from bits 15:0 without changing the active fraction. A write to address 3 (whole step, bits 7:0) loads the step and also moves the staged fraction into use, starting with the next clock.
- R5: Address 2 stages seconds bits 47:32 from write bits 15:0 and leaves the running seconds alone. A write to address 1 loads all 48 seconds at once, made of the staged upper word and the 32 written bits.
- R6: A write to address 0 loads the nanoseconds from bits 29:0 on that clock in place of the step, and the seconds stay as they were. A value of zero is accepted.
- R7: A write to address 5 applies a single adjustment on that clock, on top of the normal step. Bits 29:0 hold the magnitude, which must be below 999,999,744. Bit 31 gives the direction: 0 adds and 1 subtracts. A result below zero borrows one second, and a result of one billion or more carries one. The step registers do not change.
- R8: When both the active step and the active fraction are zero, the time holds still.
- R9: A capture holds the time as it stood just before the strobe's clock edge. In `cap_lo`, bits 29:0 are the nanoseconds and bits 31:30 are seconds bits 1:0. In `cap_hi`, bits 3:0 are seconds bits 5:2.
- R10: `cap_valid` rises the clock after an accepted strobe. While `cap_valid` is high and `cap_ready` is low, the valid signal and both words stay stable, and any new strobe is dropped. Valid falls after a clock with `cap_ready` high, unless a strobe in that same clock loads a new word.
- R11: Reads are combinational and live, with no latching. Address 0 gives the nanoseconds, 1 gives seconds 31:0, 2 gives seconds 47:32, 3 gives the active step and 4 gives the active fraction, each zero-extended. Any other address reads as zero. A roll-over between a nanoseconds read and a later seconds read can be seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for both write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Live read data for reg_addr |
| cap_strobe | input | 1 | Request a timestamp snapshot |
| cap_valid | output | 1 | Timestamp words are valid |
| cap_ready | input | 1 | Consumer takes the timestamp |
| cap_lo | output | 32 | Low seconds bits and nanoseconds |
| cap_hi | output | 4 | Seconds bits 5:2 |
| tod_sec | output | 48 | Running seconds |
| tod_ns | output | 30 | Running nanoseconds |

## Verification
The counter is tried with a half-nanosecond fraction. This separates a correct carry from a step that drops the fraction or always adds it. Nanosecond loads placed just under one billion force roll-overs, and one of them crosses the 32-bit seconds boundary, which exposes a carry lost between the two seconds words. Adjust writes are driven in both directions, with magnitudes that borrow and that carry. The capture stream is driven by directed stalls and by random strobe/ready patterns, which show whether a held word is overwritten or a hand-off is missed.

// File: rtl/ptpc_pkg.sv
package ptpc_pkg;
  typedef enum logic [2:0] {
    ADDR_NS     = 3'd0,
    ADDR_SEC_LO = 3'd1,
    ADDR_SEC_HI = 3'd2,
    ADDR_INC    = 3'd3,
    ADDR_SUBINC = 3'd4,
    ADDR_ADJ    = 3'd5
  } ptpc_addr_e;

  localparam int unsigned NS_PER_SEC = 1_000_000_000;

  typedef struct packed {
    logic ns;
    logic sec_lo;
    logic sec_hi;
    logic inc;
    logic sub;
    logic adj;
  } ptpc_wr_t;
endpackage

// File: rtl/ptpc_regif.sv
module ptpc_regif
  import ptpc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 3,
  parameter int INC_W    = 8,
  parameter int FRAC_W   = 16,
  parameter int SEC_HI_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output ptpc_wr_t            wr_s,
  output logic [INC_W-1:0]    act_inc,
  output logic [FRAC_W-1:0]   act_frac,
  output logic [SEC_HI_W-1:0] stage_hi
);
  localparam int FLD_W = (FRAC_W > SEC_HI_W) ? FRAC_W : SEC_HI_W;

  logic [FRAC_W-1:0] stage_frac;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata[DATA_W-1:FLD_W];

  // address decode into one-hot write strobes
  always_comb begin
    wr_s        = '0;
    wr_s.ns     = reg_wr && (reg_addr == ADDR_W'(ADDR_NS));
    wr_s.sec_lo = reg_wr && (reg_addr == ADDR_W'(ADDR_SEC_LO));
    wr_s.sec_hi = reg_wr && (reg_addr == ADDR_W'(ADDR_SEC_HI));
    wr_s.inc    = reg_wr && (reg_addr == ADDR_W'(ADDR_INC));
    wr_s.sub    = reg_wr && (reg_addr == ADDR_W'(ADDR_SUBINC));
    wr_s.adj    = reg_wr && (reg_addr == ADDR_W'(ADDR_ADJ));
  end

  // staged values and the active step pair
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_frac <= '0;
      stage_hi   <= '0;
      act_inc    <= '0;
      act_frac   <= '0;
    end else begin
      if (wr_s.sub)    stage_frac <= reg_wdata[FRAC_W-1:0];
      if (wr_s.sec_hi) stage_hi   <= reg_wdata[SEC_HI_W-1:0];
      if (wr_s.inc) begin
        act_inc  <= reg_wdata[INC_W-1:0];
        act_frac <= stage_frac;
      end
    end
  end
endmodule

// File: rtl/ptpc_frac_acc.sv
module ptpc_frac_acc #(
  parameter int INC_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INC_W-1:0]  act_inc,
  input  logic [FRAC_W-1:0] act_frac,
  output logic [INC_W:0]    step
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;

  assign acc_sum = {1'b0, acc_q} + {1'b0, act_frac};
  // whole step plus the carry leaving the fraction
  assign step    = {1'b0, act_inc} + {{INC_W{1'b0}}, acc_sum[FRAC_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/ptpc_time_core.sv
module ptpc_time_core
  import ptpc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NS_W     = 30,
  parameter int INC_W    = 8,
  parameter int SEC_HI_W = 16,
  parameter int ADJ_SIGN = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ptpc_wr_t                   wr_s,
  input  logic [DATA_W-1:0]          reg_wdata,
  input  logic [SEC_HI_W-1:0]        stage_hi,
  input  logic [INC_W:0]             step,
  output logic [NS_W-1:0]            ns_q,
  output logic [DATA_W+SEC_HI_W-1:0] sec_q
);
  localparam int SEC_W = DATA_W + SEC_HI_W;
  localparam int SUM_W = NS_W + 2;
  localparam logic signed [SUM_W-1:0] NPS = SUM_W'(NS_PER_SEC);

  logic signed [SUM_W-1:0] base_s, adj_s, tot_s, fix_s;
  logic [NS_W-1:0]         ns_n;
  logic [SEC_W-1:0]        sec_n;
  logic                    unused_gap;

  assign unused_gap = ^reg_wdata[ADJ_SIGN-1:NS_W];

  always_comb begin
    base_s = $signed({2'b00, ns_q}) + $signed({{(SUM_W-INC_W-1){1'b0}}, step});
    adj_s  = '0;
    if (wr_s.adj) begin
      if (reg_wdata[ADJ_SIGN]) adj_s = -$signed({2'b00, reg_wdata[NS_W-1:0]});
      else                     adj_s =  $signed({2'b00, reg_wdata[NS_W-1:0]});
    end
    tot_s = base_s + adj_s;
    sec_n = sec_q;
    fix_s = tot_s;
    if (tot_s < 0) begin
      fix_s = tot_s + NPS;
      sec_n = sec_q - SEC_W'(1);
    end else if (tot_s >= NPS) begin
      fix_s = tot_s - NPS;
      sec_n = sec_q + SEC_W'(1);
    end
    ns_n = fix_s[NS_W-1:0];
    if (wr_s.ns) begin
      ns_n  = reg_wdata[NS_W-1:0];
      sec_n = sec_q;
    end
    if (wr_s.sec_lo) sec_n = {stage_hi, reg_wdata};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_q  <= '0;
      sec_q <= '0;
    end else begin
      ns_q  <= ns_n;
      sec_q <= sec_n;
    end
  end
endmodule

// File: rtl/ptpc_capture.sv
module ptpc_capture #(
  parameter int DATA_W    = 32,
  parameter int NS_W      = 30,
  parameter int SEC_W     = 48,
  parameter int CAP_SEC_W = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cap_strobe,
  input  logic                             cap_ready,
  input  logic [NS_W-1:0]                  ns_q,
  input  logic [SEC_W-1:0]                 sec_q,
  output logic                             cap_valid,
  output logic [DATA_W-1:0]                cap_lo,
  output logic [CAP_SEC_W-(DATA_W-NS_W)-1:0] cap_hi
);
  localparam int LO_SEC = DATA_W - NS_W;

  logic load;
  logic unused_sec;

  assign unused_sec = ^sec_q[SEC_W-1:CAP_SEC_W];
  assign load       = cap_strobe && (!cap_valid || cap_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_valid <= 1'b0;
      cap_lo    <= '0;
      cap_hi    <= '0;
    end else if (load) begin
      cap_valid <= 1'b1;
      cap_lo    <= {sec_q[LO_SEC-1:0], ns_q};
      cap_hi    <= sec_q[CAP_SEC_W-1:LO_SEC];
    end else if (cap_ready) begin
      cap_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ptp_tod_counter.sv
module ptp_tod_counter
  import ptpc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int NS_W      = 30,
  parameter int INC_W     = 8,
  parameter int FRAC_W    = 16,
  parameter int SEC_HI_W  = 16,
  parameter int CAP_SEC_W = 6,
  parameter int ADJ_SIGN  = 31
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             reg_wr,
  input  logic [ADDR_W-1:0]                reg_addr,
  input  logic [DATA_W-1:0]                reg_wdata,
  output logic [DATA_W-1:0]                reg_rdata,
  input  logic                             cap_strobe,
  output logic                             cap_valid,
  input  logic                             cap_ready,
  output logic [DATA_W-1:0]                cap_lo,
  output logic [CAP_SEC_W-(DATA_W-NS_W)-1:0] cap_hi,
  output logic [DATA_W+SEC_HI_W-1:0]       tod_sec,
  output logic [NS_W-1:0]                  tod_ns
);
  localparam int SEC_W = DATA_W + SEC_HI_W;

  ptpc_wr_t            wr_s;
  logic [INC_W-1:0]    act_inc;
  logic [FRAC_W-1:0]   act_frac;
  logic [SEC_HI_W-1:0] stage_hi;
  logic [INC_W:0]      step;

  ptpc_regif #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .INC_W(INC_W),
    .FRAC_W(FRAC_W), .SEC_HI_W(SEC_HI_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wr_s(wr_s), .act_inc(act_inc),
    .act_frac(act_frac), .stage_hi(stage_hi)
  );

  ptpc_frac_acc #(.INC_W(INC_W), .FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .act_inc(act_inc), .act_frac(act_frac),
    .step(step)
  );

  ptpc_time_core #(
    .DATA_W(DATA_W), .NS_W(NS_W), .INC_W(INC_W),
    .SEC_HI_W(SEC_HI_W), .ADJ_SIGN(ADJ_SIGN)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .wr_s(wr_s), .reg_wdata(reg_wdata),
    .stage_hi(stage_hi), .step(step), .ns_q(tod_ns), .sec_q(tod_sec)
  );

  ptpc_capture #(
    .DATA_W(DATA_W), .NS_W(NS_W), .SEC_W(SEC_W), .CAP_SEC_W(CAP_SEC_W)
  ) u_cap (
    .clk(clk), .rst_n(rst_n), .cap_strobe(cap_strobe), .cap_ready(cap_ready),
    .ns_q(tod_ns), .sec_q(tod_sec), .cap_valid(cap_valid),
    .cap_lo(cap_lo), .cap_hi(cap_hi)
  );

  // live read mux, no latching
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(ADDR_NS):     reg_rdata = {{(DATA_W-NS_W){1'b0}}, tod_ns};
      ADDR_W'(ADDR_SEC_LO): reg_rdata = tod_sec[DATA_W-1:0];
      ADDR_W'(ADDR_SEC_HI): reg_rdata = {{(DATA_W-SEC_HI_W){1'b0}}, tod_sec[SEC_W-1:DATA_W]};
      ADDR_W'(ADDR_INC):    reg_rdata = {{(DATA_W-INC_W){1'b0}}, act_inc};
      ADDR_W'(ADDR_SUBINC): reg_rdata = {{(DATA_W-FRAC_W){1'b0}}, act_frac};
      default:              reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ptpc_checker.sv
module ptpc_checker
  import ptpc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3,
  parameter int NS_W      = 30,
  parameter int INC_W     = 8,
  parameter int FRAC_W    = 16,
  parameter int SEC_HI_W  = 16,
  parameter int CAP_SEC_W = 6
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             reg_wr,
  input logic [ADDR_W-1:0]                reg_addr,
  input logic [DATA_W-1:0]                reg_wdata,
  input logic [NS_W-1:0]                  tod_ns,
  input logic [DATA_W+SEC_HI_W-1:0]       tod_sec,
  input logic [INC_W-1:0]                 act_inc,
  input logic [FRAC_W-1:0]                act_frac,
  input logic                             cap_valid,
  input logic                             cap_ready,
  input logic [DATA_W-1:0]                cap_lo,
  input logic [CAP_SEC_W-(DATA_W-NS_W)-1:0] cap_hi
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (tod_ns == '0 && tod_sec == '0 && !cap_valid && act_inc == '0 && act_frac == '0));

  assert_ns_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < NS_W'(NS_PER_SEC));

  assert_sub_staged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(ADDR_SUBINC)) |=> $stable(act_frac));

  assert_sec_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(ADDR_SEC_LO)) |=> tod_sec[DATA_W-1:0] == $past(reg_wdata));

  assert_ns_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(ADDR_NS)) |=> tod_ns == $past(reg_wdata[NS_W-1:0]));

  assert_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && act_inc == '0 && act_frac == '0) |=> ($stable(tod_ns) && $stable(tod_sec)));

  assert_cap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_valid && !cap_ready) |=> (cap_valid && $stable(cap_lo) && $stable(cap_hi)));
endmodule

bind ptp_tod_counter ptpc_checker #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NS_W(NS_W), .INC_W(INC_W),
  .FRAC_W(FRAC_W), .SEC_HI_W(SEC_HI_W), .CAP_SEC_W(CAP_SEC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tod_ns(tod_ns), .tod_sec(tod_sec),
  .act_inc(act_inc), .act_frac(act_frac), .cap_valid(cap_valid),
  .cap_ready(cap_ready), .cap_lo(cap_lo), .cap_hi(cap_hi)
);

// File: tb/test_ptp_tod_counter.sv
`timescale 1ns/1ps
module test_ptp_tod_counter;
  localparam longint NPS = 1000000000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        cap_strobe = 1'b0;
  logic        cap_valid;
  logic        cap_ready = 1'b1;
  logic [31:0] cap_lo;
  logic [3:0]  cap_hi;
  logic [47:0] tod_sec;
  logic [29:0] tod_ns;

  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  longint      m_ns, m_acc, m_inc, m_frac, m_sfrac;
  logic [47:0] m_sec;
  logic [15:0] m_shi;
  bit          m_cv;
  logic [31:0] m_clo;
  logic [3:0]  m_chi;

  ptp_tod_counter i_ptp_tod_counter (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_strobe(cap_strobe),
    .cap_valid(cap_valid), .cap_ready(cap_ready), .cap_lo(cap_lo),
    .cap_hi(cap_hi), .tod_sec(tod_sec), .tod_ns(tod_ns)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // reference model, advanced on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ns = 0; m_sec = '0; m_acc = 0; m_inc = 0; m_frac = 0; m_sfrac = 0;
      m_shi = '0; m_cv = 0; m_clo = '0; m_chi = '0;
    end else begin
      longint t, sum, st;
      if (cap_strobe && (!m_cv || cap_ready)) begin
        m_cv = 1; m_clo = {m_sec[1:0], m_ns[29:0]}; m_chi = m_sec[5:2];
      end else if (cap_ready) m_cv = 0;
      sum   = m_acc + m_frac;
      st    = m_inc + (sum >> 16);
      m_acc = sum & 64'hFFFF;
      if (reg_wr && reg_addr == 3'd0) m_ns = reg_wdata[29:0];
      else begin
        t = m_ns + st;
        if (reg_wr && reg_addr == 3'd5)
          t = reg_wdata[31] ? t - longint'(reg_wdata[29:0]) : t + longint'(reg_wdata[29:0]);
        if (t < 0) begin t = t + NPS; m_sec = m_sec - 48'd1; end
        else if (t >= NPS) begin t = t - NPS; m_sec = m_sec + 48'd1; end
        m_ns = t;
      end
      if (reg_wr && reg_addr == 3'd1) m_sec = {m_shi, reg_wdata};
      if (reg_wr && reg_addr == 3'd2) m_shi = reg_wdata[15:0];
      if (reg_wr && reg_addr == 3'd4) m_sfrac = reg_wdata[15:0];
      if (reg_wr && reg_addr == 3'd3) begin m_inc = reg_wdata[7:0]; m_frac = m_sfrac; end
    end
  end

  function automatic longint model_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_ns;
      3'd1: return longint'(m_sec[31:0]);
      3'd2: return longint'(m_sec[47:32]);
      3'd3: return m_inc;
      3'd4: return m_frac;
      default: return 0;
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, tod_ns, m_ns);
      check(cur_req, tod_sec, m_sec);
      check("R11", reg_rdata, model_rd(reg_addr));
      check("R10", cap_valid, m_cv);
      if (m_cv) begin
        check("R9", cap_lo, m_clo);
        check("R9", cap_hi, m_chi);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    longint a, b, s0;
    logic [31:0] held;
    // R1: reset state
    idle(3);
    check("R1", tod_ns, 0); check("R1", tod_sec, 0); check("R1", cap_valid, 0);
    rst_n = 1'b1;
    idle(4);
    cur_req = "R8";
    check("R8", tod_ns, 0);

    // R4: staged fraction stays inactive
    cur_req = "R4";
    wr(3'd4, 32'h0000_8000);
    reg_addr = 3'd4;
    idle(3);
    @(negedge clk);
    check("R4", reg_rdata, 0);
    check("R4", tod_ns, 0);
    wr(3'd3, 32'd8);
    // R2: step 8 with half fraction gives 17 per two clocks
    cur_req = "R2";
    idle(3);
    @(negedge clk); a = tod_ns;
    @(negedge clk); @(negedge clk); b = tod_ns;
    check("R2", b - a, 17);
    idle(10);

    // R5: upper seconds staged, committed by low write
    cur_req = "R5";
    wr(3'd2, 32'h0000_0001);
    idle(2);
    check("R5", tod_sec, 0);
    wr(3'd1, 32'hFFFF_FFFE);
    check("R5", tod_sec, 48'h1_FFFF_FFFE);

    // R6: direct load including zero
    cur_req = "R6";
    wr(3'd0, 32'd0);
    check("R6", tod_ns, 0);
    check("R6", tod_sec, 48'h1_FFFF_FFFE);

    // R3: roll-overs, including the 32-bit seconds boundary
    cur_req = "R3";
    wr(3'd0, 32'd999_999_900);
    idle(20);
    check("R3", tod_sec, 48'h1_FFFF_FFFF);
    wr(3'd0, 32'd999_999_950);
    idle(10);
    check("R3", tod_sec, 48'h2_0000_0000);

    // R7: adjust with borrow and with carry
    cur_req = "R7";
    wr(3'd0, 32'd100);
    s0 = tod_sec;
    wr(3'd5, 32'h8000_0000 | 32'd1000);
    check("R7", tod_sec, s0 - 1);
    wr(3'd0, 32'd999_999_000);
    s0 = tod_sec;
    wr(3'd5, 32'd5000);
    check("R7", tod_sec, s0 + 1);
    wr(3'd5, 32'h8000_0000 | 32'd300);
    idle(5);
    reg_addr = 3'd3;
    @(negedge clk);
    check("R7", reg_rdata, 8);

    // R11: live read exposes roll-over between two reads
    cur_req = "R11";
    wr(3'd4, 32'd0);
    wr(3'd3, 32'd8);
    wr(3'd0, 32'd0);
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd5);
    wr(3'd0, 32'd999_999_976);
    reg_addr = 3'd0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    a = reg_rdata;
    @(posedge clk); #1;
    reg_addr = 3'd1;
    @(negedge clk);
    b = reg_rdata;
    check("R11", a, 999_999_992);
    check("R11", b, 6);

    // R10: stalled capture holds, extra strobe is dropped
    cur_req = "R10";
    cap_ready = 1'b0;
    @(posedge clk); #1; cap_strobe = 1'b1;
    @(posedge clk); #1; cap_strobe = 1'b0;
    idle(2);
    held = cap_lo;
    check("R10", cap_valid, 1);
    @(posedge clk); #1; cap_strobe = 1'b1;
    @(posedge clk); #1; cap_strobe = 1'b0;
    idle(3);
    check("R10", cap_lo, held);
    cap_ready = 1'b1;
    idle(2);
    check("R10", cap_valid, 0);
    for (int i = 0; i < 300; i++) begin
      @(posedge clk); #1;
      cap_strobe = ($urandom % 2) == 1;
      cap_ready  = ($urandom % 4) != 0;
    end
    @(posedge clk); #1; cap_strobe = 1'b0; cap_ready = 1'b1;
    idle(2);

    // R8: zero step and fraction stops the counter
    cur_req = "R8";
    wr(3'd4, 32'd0);
    wr(3'd3, 32'd0);
    idle(2);
    a = tod_ns;
    idle(10);
    check("R8", tod_ns, a);

    // R9: capture format with known seconds
    cur_req = "R9";
    wr(3'd2, 32'd0);
    wr(3'd1, 32'd45);
    @(posedge clk); #1; cap_strobe = 1'b1;
    @(posedge clk); #1; cap_strobe = 1'b0;
    check("R9", cap_lo, {2'b01, a[29:0]});
    check("R9", cap_hi, 4'b1011);
    idle(3);
    finish_run();
  end
endmodule